// File: doc/BRIEF.md
# IEEE Double Operand Input Screener

This block examines a 64-bit IEEE 754 double-precision source operand in the same cycle it is offered to an execution unit. It decides whether the operand is one the downstream datapath refuses to handle, and if so it asks for an invalid-operation trap. It can also ask for the sticky invalid status bit to be set, and it marks a trap as software-completion when the operation was issued in that mode.

Three screening rule sets exist, picked per operand by a two-bit mode code. Arithmetic operations without software completion reject every non-finite operand and every subnormal one. Comparisons without software completion accept infinities but reject NaNs and subnormals. Operations with software completion reject only subnormals, and a flush-inputs-to-zero control turns that rejection off. The block is purely combinational, and a valid strobe gates every output.

Top module: `operand_screen`

## Requirements
- R1: While `opValid` is 0, `trapReq`, `swcTag` and `setStickyInv` are all 0, whatever the other inputs are.
- R2: In arithmetic mode (`screenMode` = 0), an operand whose exponent field (bits 62:52) is zero and whose fraction field (bits 51:0) is nonzero raises `trapReq`. `setStickyInv` and `swcTag` stay 0.
- R3: In arithmetic mode, an operand whose exponent field is all ones raises both `trapReq` and `setStickyInv`, for an infinity as well as for a NaN, and `swcTag` stays 0.
- R4: In comparison mode (`screenMode` = 1), an all-ones exponent with a nonzero fraction (a NaN) raises `trapReq` and `setStickyInv`. An all-ones exponent with a zero fraction (an infinity) raises nothing.
- R5: In comparison mode, a subnormal operand (zero exponent, nonzero fraction) raises `trapReq` without `setStickyInv` and without `swcTag`.
- R6: In software-completion mode (`screenMode` = 2) with `flushInputs` at 0, a subnormal operand of either sign (bit 63) raises `trapReq` and `swcTag`, and `setStickyInv` stays 0.
- R7: In software-completion mode with `flushInputs` at 1, a subnormal operand raises nothing.
- R8: In software-completion mode, infinities and NaNs raise nothing.
- R9: Zeros of either sign and normal finite operands raise nothing in any mode.
- R10: Mode code 3 is reserved and raises nothing for any operand.
- R11: `flushInputs` has no effect in arithmetic or comparison mode.
- R12: `swcTag` and `setStickyInv` are only ever 1 while `trapReq` is 1, and `swcTag` is only ever 1 in software-completion mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opValid | input | 1 | Operand present this cycle. Gates all outputs |
| screenMode | input | 2 | Rule set: 0 arithmetic, 1 comparison, 2 software completion, 3 reserved |
| flushInputs | input | 1 | Subnormal inputs are flushed to zero downstream. Honoured in mode 2 only |
| opData | input | 64 | Double-precision operand: sign bit 63, exponent 62:52, fraction 51:0 |
| trapReq | output | 1 | Invalid-operation trap request |
| swcTag | output | 1 | Trap belongs to a software-completion operation |
| setStickyInv | output | 1 | Request to set the sticky invalid status bit |

## Verification
Two results can land together on one operand. A trap request can come with a sticky-invalid request, which happens for non-finite operands in arithmetic mode and for NaNs in comparison mode. A trap request can also come with the software-completion tag, which happens for subnormals in mode 2. The bench provokes both pairs with directed operands, including negative subnormals and negative NaNs, and with a random sweep that favours the zero and all-ones exponent encodings. It compares all three outputs against its own reference model in every cycle, so an output that rises alone, or one that is missing from the pair, fails. The checker also enforces that neither companion output ever appears without a trap.

// File: rtl/screen_pkg.sv
package screen_pkg;

  // Rule set selector, encoding fixed by the mode input of the top module.
  typedef enum logic [1:0] {
    MODE_ARITH = 2'd0,
    MODE_CMP   = 2'd1,
    MODE_SWC   = 2'd2,
    MODE_RSVD  = 2'd3
  } screenMode_e;

  // Operand class flags produced by the field decoder (mutually exclusive
  // except that isNorm covers every finite nonzero value with a live exponent).
  typedef struct packed {
    logic isZero;
    logic isSub;
    logic isInf;
    logic isNan;
    logic isNorm;
  } opClass_t;

  // Strobes from the rule control to the output stage.
  typedef struct packed {
    logic trap;
    logic swc;
    logic setInv;
  } screenStrobe_t;

endpackage

// File: rtl/screen_field_decode.sv
module screen_field_decode
  import screen_pkg::*;
#(
  parameter  int EXP_W  = 11,
  parameter  int FRAC_W = 52,
  parameter  int SEG_W  = 13,
  localparam int DATA_W = 1 + EXP_W + FRAC_W,
  localparam int NSEG   = (FRAC_W + SEG_W - 1) / SEG_W
) (
  input  logic [DATA_W-1:0] opData,
  output opClass_t          opClass
);

  logic [EXP_W-1:0]  expField;
  logic [FRAC_W-1:0] fracField;
  logic [NSEG-1:0]   segAny;
  logic              expZero;
  logic              expOnes;
  logic              fracAny;

  assign expField  = opData[FRAC_W +: EXP_W];
  assign fracField = opData[FRAC_W-1:0];

  // Fraction nonzero detect split into segments so the OR tree is balanced.
  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    localparam int LO = s * SEG_W;
    localparam int HI = ((LO + SEG_W) > FRAC_W) ? FRAC_W - 1 : LO + SEG_W - 1;
    assign segAny[s] = |fracField[HI:LO];
  end

  assign fracAny = |segAny;
  assign expZero = ~|expField;
  assign expOnes = &expField;

  always_comb begin
    opClass        = '0;
    opClass.isZero = expZero & ~fracAny;
    opClass.isSub  = expZero &  fracAny;
    opClass.isInf  = expOnes & ~fracAny;
    opClass.isNan  = expOnes &  fracAny;
    opClass.isNorm = ~expZero & ~expOnes;
  end

endmodule

// File: rtl/screen_rule_ctrl.sv
module screen_rule_ctrl
  import screen_pkg::*;
(
  input  logic          opValid,
  input  logic [1:0]    screenMode,
  input  logic          flushInputs,
  input  opClass_t      opClass,
  output screenStrobe_t strobes
);

  screenMode_e modeSel;

  assign modeSel = screenMode_e'(screenMode);

  always_comb begin
    strobes = '0;
    if (opValid) begin
      unique case (modeSel)
        MODE_ARITH: begin
          // every non-finite input is refused and recorded as invalid
          strobes.trap   = opClass.isSub | opClass.isInf | opClass.isNan;
          strobes.setInv = opClass.isInf | opClass.isNan;
        end
        MODE_CMP: begin
          // infinities are legal comparison operands
          strobes.trap   = opClass.isSub | opClass.isNan;
          strobes.setInv = opClass.isNan;
        end
        MODE_SWC: begin
          strobes.trap = opClass.isSub & ~flushInputs;
          strobes.swc  = opClass.isSub & ~flushInputs;
        end
        MODE_RSVD: begin
          strobes = '0;
        end
        default: strobes = '0;
      endcase
    end
  end

endmodule

// File: rtl/operand_screen.sv
module operand_screen
  import screen_pkg::*;
#(
  parameter  int EXP_W  = 11,
  parameter  int FRAC_W = 52,
  localparam int DATA_W = 1 + EXP_W + FRAC_W
) (
  input  logic              opValid,
  input  logic [1:0]        screenMode,
  input  logic              flushInputs,
  input  logic [DATA_W-1:0] opData,
  output logic              trapReq,
  output logic              swcTag,
  output logic              setStickyInv
);

  opClass_t      opClass;
  screenStrobe_t strobes;

  screen_field_decode #(
    .EXP_W (EXP_W),
    .FRAC_W(FRAC_W)
  ) decode_i (
    .opData (opData),
    .opClass(opClass)
  );

  screen_rule_ctrl ctrl_i (
    .opValid    (opValid),
    .screenMode (screenMode),
    .flushInputs(flushInputs),
    .opClass    (opClass),
    .strobes    (strobes)
  );

  assign trapReq      = strobes.trap;
  assign swcTag       = strobes.swc;
  assign setStickyInv = strobes.setInv;

endmodule

// File: rtl/operand_screen_chk.sv
module operand_screen_chk #(
  parameter  int EXP_W  = 11,
  parameter  int FRAC_W = 52,
  localparam int DATA_W = 1 + EXP_W + FRAC_W
) (
  input logic              opValid,
  input logic [1:0]        screenMode,
  input logic              flushInputs,
  input logic [DATA_W-1:0] opData,
  input logic              trapReq,
  input logic              swcTag,
  input logic              setStickyInv
);

  logic zeroOperand;
  assign zeroOperand = (opData[DATA_W-2:0] == '0);

  always_comb begin
    // R1
    idle_quiet_chk: assert (opValid || !(trapReq || swcTag || setStickyInv))
      else $error("outputs active without a valid operand");
    // R12
    swc_needs_trap_chk: assert (!swcTag || trapReq)
      else $error("software-completion tag without trap");
    // R12
    inv_needs_trap_chk: assert (!setStickyInv || trapReq)
      else $error("sticky invalid request without trap");
    // R12
    swc_mode_only_chk: assert (!swcTag || screenMode == 2'd2)
      else $error("software-completion tag outside mode 2");
    // R10
    reserved_quiet_chk: assert (screenMode != 2'd3 || !trapReq)
      else $error("trap in reserved mode");
    // R9
    zero_passes_chk: assert (!zeroOperand || !trapReq)
      else $error("trap on a zero operand");
    // R7
    flush_no_trap_chk: assert (!(screenMode == 2'd2 && flushInputs) || !trapReq)
      else $error("trap in mode 2 while flushing inputs");
  end

endmodule

bind operand_screen operand_screen_chk #(
  .EXP_W (EXP_W),
  .FRAC_W(FRAC_W)
) chk_i (
  .opValid     (opValid),
  .screenMode  (screenMode),
  .flushInputs (flushInputs),
  .opData      (opData),
  .trapReq     (trapReq),
  .swcTag      (swcTag),
  .setStickyInv(setStickyInv)
);

// File: tb/operand_screen_tb_top.sv
`timescale 1ns/1ps
module operand_screen_tb_top;

  logic        clk = 1'b0;
  logic        opValid = 1'b0;
  logic [1:0]  screenMode = 2'd0;
  logic        flushInputs = 1'b0;
  logic [63:0] opData = 64'd0;
  logic        trapReq;
  logic        swcTag;
  logic        setStickyInv;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  operand_screen dut_i (
    .opValid     (opValid),
    .screenMode  (screenMode),
    .flushInputs (flushInputs),
    .opData      (opData),
    .trapReq     (trapReq),
    .swcTag      (swcTag),
    .setStickyInv(setStickyInv)
  );

  // Behavioural reference: decides from the numeric meaning of the fields.
  function automatic void refModel(input bit v, input int mode, input bit fl,
                                   input logic [63:0] d,
                                   output bit t, output bit s, output bit i,
                                   output string req);
    int    e;
    bit    fracNz;
    e      = int'(d[62:52]);
    fracNz = (d[51:0] != 52'd0);
    t = 0; s = 0; i = 0;
    if (!v) begin
      req = "R1";
    end else if (mode == 3) begin
      req = "R10";
    end else if (e != 0 && e != 2047) begin
      req = "R9";
    end else if (e == 0 && !fracNz) begin
      req = "R9";
    end else if (mode == 0) begin
      if (e == 0) begin t = 1; req = "R2"; end
      else begin t = 1; i = 1; req = "R3"; end
    end else if (mode == 1) begin
      if (e == 0) begin t = 1; req = "R5"; end
      else if (fracNz) begin t = 1; i = 1; req = "R4"; end
      else req = "R4";
    end else begin
      if (e == 2047) req = "R8";
      else if (fl) req = "R7";
      else begin t = 1; s = 1; req = "R6"; end
    end
  endfunction

  task automatic applyVec(input bit v, input int mode, input bit fl,
                          input logic [63:0] d, input string reqOverride);
    bit t, s, i;
    string req;
    @(posedge clk);
    #2;
    opValid     = v;
    screenMode  = mode[1:0];
    flushInputs = fl;
    opData      = d;
    @(negedge clk);
    refModel(v, mode, fl, d, t, s, i, req);
    if (reqOverride != "") req = reqOverride;
    checks++;
    if (trapReq !== t || swcTag !== s || setStickyInv !== i) begin
      errors++;
      $display("FAIL %s: mode=%0d flush=%0b valid=%0b data=%h actual trap/swc/inv=%b%b%b expected=%b%b%b",
               req, mode, fl, v, d, trapReq, swcTag, setStickyInv, t, s, i);
    end
    // R12: companions never appear without a trap
    checks++;
    if ((swcTag || setStickyInv) && !trapReq) begin
      errors++;
      $display("FAIL R12: companion without trap actual trap/swc/inv=%b%b%b expected trap=1",
               trapReq, swcTag, setStickyInv);
    end
  endtask

  localparam logic [63:0] POS_ZERO = 64'h0000_0000_0000_0000;
  localparam logic [63:0] NEG_ZERO = 64'h8000_0000_0000_0000;
  localparam logic [63:0] SUB_MIN  = 64'h0000_0000_0000_0001;
  localparam logic [63:0] SUB_NEG  = 64'h800F_FFFF_FFFF_FFFF;
  localparam logic [63:0] POS_INF  = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] NEG_INF  = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] QNAN     = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] SNAN_NEG = 64'hFFF0_0000_0000_0001;
  localparam logic [63:0] ONE      = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] MAX_NORM = 64'h7FEF_FFFF_FFFF_FFFF;
  localparam logic [63:0] MIN_NORM = 64'h0010_0000_0000_0000;

  initial begin : watchdog
    #(20ns * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    // R1: reset-like idle state and invalid gating
    applyVec(0, 0, 0, POS_ZERO, "R1");
    applyVec(0, 0, 0, QNAN, "R1");
    applyVec(0, 2, 0, SUB_MIN, "R1");
    applyVec(0, 1, 1, SNAN_NEG, "R1");

    // R2 / R3 arithmetic mode
    applyVec(1, 0, 0, SUB_MIN, "R2");
    applyVec(1, 0, 0, SUB_NEG, "R2");
    applyVec(1, 0, 0, POS_INF, "R3");
    applyVec(1, 0, 0, NEG_INF, "R3");
    applyVec(1, 0, 0, QNAN, "R3");
    applyVec(1, 0, 0, SNAN_NEG, "R3");

    // R4 / R5 comparison mode
    applyVec(1, 1, 0, POS_INF, "R4");
    applyVec(1, 1, 0, NEG_INF, "R4");
    applyVec(1, 1, 0, QNAN, "R4");
    applyVec(1, 1, 0, SNAN_NEG, "R4");
    applyVec(1, 1, 0, SUB_MIN, "R5");
    applyVec(1, 1, 0, SUB_NEG, "R5");

    // R6 / R7 / R8 software-completion mode
    applyVec(1, 2, 0, SUB_MIN, "R6");
    applyVec(1, 2, 0, SUB_NEG, "R6");
    applyVec(1, 2, 1, SUB_MIN, "R7");
    applyVec(1, 2, 1, SUB_NEG, "R7");
    applyVec(1, 2, 0, POS_INF, "R8");
    applyVec(1, 2, 0, SNAN_NEG, "R8");
    applyVec(1, 2, 1, QNAN, "R8");

    // R9 zeros and normals in every mode
    for (int m = 0; m < 3; m++) begin
      applyVec(1, m, 0, POS_ZERO, "R9");
      applyVec(1, m, 0, NEG_ZERO, "R9");
      applyVec(1, m, 0, ONE, "R9");
      applyVec(1, m, 0, MAX_NORM, "R9");
      applyVec(1, m, 0, MIN_NORM, "R9");
    end

    // R10 reserved mode
    applyVec(1, 3, 0, SUB_MIN, "R10");
    applyVec(1, 3, 0, QNAN, "R10");
    applyVec(1, 3, 1, POS_INF, "R10");

    // R11 flush control ignored outside mode 2
    applyVec(1, 0, 1, SUB_MIN, "R11");
    applyVec(1, 0, 1, POS_INF, "R11");
    applyVec(1, 1, 1, SUB_NEG, "R11");
    applyVec(1, 1, 1, QNAN, "R11");
    applyVec(1, 1, 1, NEG_INF, "R11");

    // Random sweep biased toward the special exponent encodings
    for (int n = 0; n < 600; n++) begin
      logic [63:0] d;
      int pick;
      d    = {$urandom, $urandom};
      pick = $urandom % 6;
      if (pick == 0) d[62:52] = 11'h000;
      else if (pick == 1) d[62:52] = 11'h7FF;
      else if (pick == 2) begin d[62:52] = 11'h000; d[51:0] = '0; end
      else if (pick == 3) begin d[62:52] = 11'h7FF; d[51:0] = '0; end
      else if (pick == 4) begin d[62:52] = 11'h000; d[51:0] = 52'd1 << ($urandom % 52); end
      applyVec(($urandom % 8) != 0, $urandom % 4, $urandom % 2, d, "");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule